// File: doc/BRIEF.md
# Half-Bridge Gate Driver Command Logic

This block is the cycle-based digital front end of a two-channel half-bridge gate driver. It takes a command for the upper (floating) switch and one for the lower (ground-referenced) switch. It also takes an active-high shutdown request and two undervoltage flags that have already been digitised, one for the lower-side supply and one for the floating supply. From these it produces one gate-enable output per channel.

Each command first passes through a glitch filter. The filter rejects any level that does not persist for `FILT_CYC` clocks. A shutdown request drops both gates at the next clock and sets a per-channel latch. That latch holds its channel off after shutdown is removed, until the channel sees a fresh filtered rising command. The two undervoltage flags release in different ways. When the lower-supply flag clears, the lower gate follows its command level again. When either flag clears, the upper channel stays off until its next rising command edge. Turn-on is slower than turn-off by `ON_DLY` clocks, so complementary commands never overlap at the outputs.

Top module: `hbd_input_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock after its release, both `hi_gate` and `lo_gate` are 0, even with both commands held high.
- R2: A command level that lasts fewer than `FILT_CYC` consecutive clocks has no effect on the gate outputs. A level that lasts `FILT_CYC` clocks or more is accepted. A command pulse of width W clocks (W >= `FILT_CYC` > `ON_DLY`) with nothing else blocking it keeps its gate high for exactly W - `ON_DLY` clocks.
- R3: With nothing blocking, a gate rises `FILT_CYC` + `ON_DLY` + 1 clocks after the first clock edge that samples the new high command level. It falls `FILT_CYC` + 1 clocks after the first edge that samples the low level.
- R4: `shut_req` = 1 forces both gates to 0 from the next clock on, for as long as it stays high.
- R5: After `shut_req` returns to 0, a channel whose command stayed high remains off. It is re-enabled only by a new filtered rising edge of its own command, and that edge does not release the other channel.
- R6: `uv_lo` = 1 forces both gates to 0 from the next clock on.
- R7: When `uv_lo` returns to 0 while the lower command is held high, `lo_gate` rises `ON_DLY` + 1 clocks later, with no new command edge needed.
- R8: `uv_hi` = 1 forces `hi_gate` to 0 from the next clock on, and `lo_gate` is unaffected. After `uv_hi` or `uv_lo` is released, `hi_gate` stays 0 while the upper command is held high. Only the next filtered rising edge of `hi_cmd` turns it on.
- R9: When `hi_cmd` and `lo_cmd` are driven as complements of each other, `hi_gate` and `lo_gate` are never both 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hi_cmd | input | 1 | Upper-switch command |
| lo_cmd | input | 1 | Lower-switch command |
| shut_req | input | 1 | Shutdown request, active high |
| uv_lo | input | 1 | Lower-side supply undervoltage flag, active high |
| uv_hi | input | 1 | Floating supply undervoltage flag, active high |
| hi_gate | output | 1 | Upper gate enable |
| lo_gate | output | 1 | Lower gate enable |

## Verification
The embedded properties assume that every input is synchronous to `clk` and changes only between edges. They also assume that `FILT_CYC` is at least 2 and `ON_DLY` at least 1, since the filter and delay checks look back two cycles. The stimulus drives all inputs on the falling edge and uses the default filter and delay values. It holds each command level long enough to cross the filter whenever a gate change is expected. The non-overlap property is checked only while the two commands are strict complements, because independent commands may legitimately be high together.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    localparam int NCH   = 2;
    localparam int CH_HI = 0;
    localparam int CH_LO = 1;

    localparam int FILT_CYC_DEF = 10;
    localparam int ON_DLY_DEF   = 5;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } chan_ev_t;

    function automatic chan_ev_t mk_ev(input logic cur, input logic prev);
        chan_ev_t e;
        e.lvl  = cur;
        e.rise = cur & ~prev;
        e.fall = ~cur & prev;
        return e;
    endfunction

    function automatic int cnt_width(input int limit);
        return (limit > 0) ? $clog2(limit + 1) : 1;
    endfunction

endpackage

// File: rtl/hbd_glitch_filter.sv
module hbd_glitch_filter
    import hbd_pkg::*;
#(
    parameter int FILT_CYC = FILT_CYC_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic level_o
);

    localparam int CW = cnt_width(FILT_CYC);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            level_o <= 1'b0;
        end else if (raw == level_o) begin
            run_cnt <= '0;
        end else if (run_cnt == LAST) begin
            run_cnt <= '0;
            level_o <= raw;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R2: the accepted level was present on the raw input over the last samples
    a_r2_filter_settled: assert property (@(posedge clk) disable iff (rst)
        !$stable(level_o) |-> ($past(raw) == level_o))
        else $error("R2 filter output changed without a settled input");

    generate
        if (FILT_CYC >= 2) begin : g_two_deep
            a_r2_filter_two_deep: assert property (@(posedge clk) disable iff (rst)
                !$stable(level_o) |-> ($past(raw, 2) == level_o))
                else $error("R2 filter accepted a one-cycle level");
        end
    endgenerate

endmodule

// File: rtl/hbd_on_delay.sv
module hbd_on_delay
    import hbd_pkg::*;
#(
    parameter int ON_DLY = ON_DLY_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic gate
);

    localparam int CW = cnt_width(ON_DLY);
    localparam logic [CW-1:0] TOP = CW'(ON_DLY);

    logic [CW-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
            gate     <= 1'b0;
        end else if (!req) begin
            hold_cnt <= '0;
            gate     <= 1'b0;
        end else if (hold_cnt == TOP) begin
            gate <= 1'b1;
        end else begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end

    // R3: turn-off is one register stage
    a_r3_off_fast: assert property (@(posedge clk) disable iff (rst)
        !req |=> !gate)
        else $error("R3 gate stayed on after request dropped");

    generate
        if (ON_DLY >= 1) begin : g_hold_chk
            // R3: turn-on requires the request to have persisted
            a_r3_on_held: assert property (@(posedge clk) disable iff (rst)
                $rose(gate) |-> ($past(req) && $past(req, 2)))
                else $error("R3 gate rose without a held request");
        end
    endgenerate

endmodule

// File: rtl/hbd_input_ctrl.sv
module hbd_input_ctrl
    import hbd_pkg::*;
#(
    parameter int FILT_CYC = FILT_CYC_DEF,
    parameter int ON_DLY   = ON_DLY_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic hi_cmd,
    input  logic lo_cmd,
    input  logic shut_req,
    input  logic uv_lo,
    input  logic uv_hi,
    output logic hi_gate,
    output logic lo_gate
);

    logic [NCH-1:0] cmd_raw;
    logic [NCH-1:0] filt_lvl;
    logic [NCH-1:0] lvl_q;
    logic [NCH-1:0] sd_lat;
    logic [NCH-1:0] sd_block;
    logic [NCH-1:0] req;
    logic [NCH-1:0] gate;
    chan_ev_t       ev [NCH];
    logic           hs_arm;
    logic           hs_uv;

    assign cmd_raw[CH_HI] = hi_cmd;
    assign cmd_raw[CH_LO] = lo_cmd;
    assign hs_uv          = uv_hi | uv_lo;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            hbd_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt (
                .clk     (clk),
                .rst     (rst),
                .raw     (cmd_raw[c]),
                .level_o (filt_lvl[c])
            );

            hbd_on_delay #(.ON_DLY(ON_DLY)) u_dly (
                .clk  (clk),
                .rst  (rst),
                .req  (req[c]),
                .gate (gate[c])
            );
        end
    endgenerate

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            ev[c]       = mk_ev(filt_lvl[c], lvl_q[c]);
            sd_block[c] = shut_req | (sd_lat[c] & ~ev[c].rise);
        end
        req[CH_LO] = ev[CH_LO].lvl & ~sd_block[CH_LO] & ~uv_lo;
        req[CH_HI] = ev[CH_HI].lvl & ~sd_block[CH_HI] & ~hs_uv
                   & (hs_arm | ev[CH_HI].rise);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= '0;
            sd_lat <= '0;
            hs_arm <= 1'b0;
        end else begin
            lvl_q <= filt_lvl;
            for (int c = 0; c < NCH; c++) begin
                if (shut_req)
                    sd_lat[c] <= 1'b1;
                else if (ev[c].rise)
                    sd_lat[c] <= 1'b0;
            end
            if (hs_uv)
                hs_arm <= 1'b0;
            else if (ev[CH_HI].rise)
                hs_arm <= 1'b1;
        end
    end

    assign hi_gate = gate[CH_HI];
    assign lo_gate = gate[CH_LO];

    a_r4_shut_off: assert property (@(posedge clk) disable iff (rst)
        shut_req |=> (!hi_gate && !lo_gate))
        else $error("R4 gate on after shutdown");

    a_r5_latch_hold_hi: assert property (@(posedge clk) disable iff (rst)
        (sd_lat[CH_HI] && !ev[CH_HI].rise) |=> !hi_gate)
        else $error("R5 upper gate on while latched");

    a_r5_latch_hold_lo: assert property (@(posedge clk) disable iff (rst)
        (sd_lat[CH_LO] && !ev[CH_LO].rise) |=> !lo_gate)
        else $error("R5 lower gate on while latched");

    a_r6_uvlo_off: assert property (@(posedge clk) disable iff (rst)
        uv_lo |=> (!hi_gate && !lo_gate))
        else $error("R6 gate on during lower-supply undervoltage");

    a_r8_uvhi_off: assert property (@(posedge clk) disable iff (rst)
        uv_hi |=> !hi_gate)
        else $error("R8 upper gate on during floating undervoltage");

    a_r8_no_level_rearm: assert property (@(posedge clk) disable iff (rst)
        (!hs_arm && !ev[CH_HI].rise) |=> !hi_gate)
        else $error("R8 upper gate on without a fresh edge");

endmodule

// File: tb/test_hbd_input_ctrl.sv
`timescale 1ns/1ps
module test_hbd_input_ctrl;

    localparam int F  = 10;
    localparam int D  = 5;
    localparam int LAT_ON  = F + D + 1;
    localparam int LAT_OFF = F + 1;

    logic clk = 1'b0;
    logic rst, hi_cmd, lo_cmd, shut_req, uv_lo, uv_hi;
    logic hi_gate, lo_gate;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;
    bit mon_en = 0;
    int overlap = 0;

    always #5 clk = ~clk;

    hbd_input_ctrl #(.FILT_CYC(F), .ON_DLY(D)) i_hbd_input_ctrl (
        .clk(clk), .rst(rst), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
        .shut_req(shut_req), .uv_lo(uv_lo), .uv_hi(uv_hi),
        .hi_gate(hi_gate), .lo_gate(lo_gate)
    );

    always @(negedge clk) begin
        if (mon_en && hi_gate && lo_gate) overlap++;
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
                finish_run();
            end
        end
    end

    initial begin
        rst = 1; hi_cmd = 1; lo_cmd = 1; shut_req = 0; uv_lo = 0; uv_hi = 0;
        @(negedge clk);
        step(3);
        // R1: reset state
        chk("R1 hi during reset", hi_gate, 0);
        chk("R1 lo during reset", lo_gate, 0);
        rst = 0;
        step(1);
        chk("R1 hi after release", hi_gate, 0);
        chk("R1 lo after release", lo_gate, 0);
        hi_cmd = 0; lo_cmd = 0;
        step(30);

        // R3: latency on and off, both channels
        lo_cmd = 1;
        step(LAT_ON - 1); chk("R3 lo before on", lo_gate, 0);
        step(1);          chk("R3 lo on", lo_gate, 1);
        lo_cmd = 0;
        step(LAT_OFF - 1); chk("R3 lo before off", lo_gate, 1);
        step(1);           chk("R3 lo off", lo_gate, 0);
        hi_cmd = 1;
        step(LAT_ON - 1); chk("R3 hi before on", hi_gate, 0);
        step(1);          chk("R3 hi on", hi_gate, 1);
        hi_cmd = 0;
        step(LAT_OFF - 1); chk("R3 hi before off", hi_gate, 1);
        step(1);           chk("R3 hi off", hi_gate, 0);
        step(20);

        // R2: pulse width sweep on each channel
        for (int ch = 0; ch < 2; ch++) begin
            for (int w = 1; w <= F + 6; w++) begin
                int hcount;
                hcount = 0;
                if (ch == 0) hi_cmd = 1; else lo_cmd = 1;
                for (int k = 0; k < w; k++) begin
                    step(1);
                    if ((ch == 0 ? hi_gate : lo_gate) == 1'b1) hcount++;
                end
                if (ch == 0) hi_cmd = 0; else lo_cmd = 0;
                for (int k = 0; k < 3 * F; k++) begin
                    step(1);
                    if ((ch == 0 ? hi_gate : lo_gate) == 1'b1) hcount++;
                end
                chk(ch == 0 ? "R2 hi pulse width" : "R2 lo pulse width",
                    hcount, (w >= F) ? (w - D) : 0);
            end
        end

        // R4 / R5: shutdown and latched release
        hi_cmd = 1; lo_cmd = 1;
        step(LAT_ON + 2);
        chk("R4 hi on before shutdown", hi_gate, 1);
        shut_req = 1;
        step(1);
        chk("R4 hi forced off", hi_gate, 0);
        chk("R4 lo forced off", lo_gate, 0);
        step(5);
        shut_req = 0;
        step(40);
        chk("R5 hi held off", hi_gate, 0);
        chk("R5 lo held off", lo_gate, 0);
        lo_cmd = 0;
        step(F + 2);
        lo_cmd = 1;
        step(LAT_ON);
        chk("R5 lo released by edge", lo_gate, 1);
        chk("R5 hi still latched", hi_gate, 0);
        hi_cmd = 0;
        step(F + 2);
        hi_cmd = 1;
        step(LAT_ON);
        chk("R5 hi released by edge", hi_gate, 1);

        // R6 / R7 / R8: lower-supply undervoltage
        uv_lo = 1;
        step(1);
        chk("R6 hi blocked", hi_gate, 0);
        chk("R6 lo blocked", lo_gate, 0);
        step(10);
        uv_lo = 0;
        step(D);     chk("R7 lo before level restart", lo_gate, 0);
        step(1);     chk("R7 lo follows level", lo_gate, 1);
        step(30);    chk("R8 hi not restored by uv_lo release", hi_gate, 0);
        hi_cmd = 0;
        step(F + 2);
        hi_cmd = 1;
        step(LAT_ON);
        chk("R8 hi restored by edge", hi_gate, 1);

        // R8: floating-supply undervoltage
        uv_hi = 1;
        step(1);
        chk("R8 hi blocked", hi_gate, 0);
        chk("R8 lo unaffected", lo_gate, 1);
        step(10);
        uv_hi = 0;
        step(40);
        chk("R8 hi held off after release", hi_gate, 0);
        hi_cmd = 0;
        step(F + 2);
        hi_cmd = 1;
        step(LAT_ON);
        chk("R8 hi on after new edge", hi_gate, 1);

        // R9: complementary toggling sweep
        hi_cmd = 0; lo_cmd = 0;
        step(3 * F);
        overlap = 0;
        mon_en = 1;
        for (int dw = 1; dw <= F + 10; dw++) begin
            for (int rep = 0; rep < 3; rep++) begin
                hi_cmd = 1; lo_cmd = 0;
                step(dw);
                hi_cmd = 0; lo_cmd = 1;
                step(dw + (rep % 2));
            end
        end
        step(3 * F);
        mon_en = 0;
        chk("R9 no overlap cycles", overlap, 0);

        done = 1;
        finish_run();
    end

endmodule